// File: doc/BRIEF.md
# GPIO bank with edge detection

This block is one bank of general-purpose pins behind a small memory-mapped register bus. Software picks which pins drive, what level each driven pin carries, and which input transitions should be captured. Every control value changes only through paired write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write sequence to alter a single pin.

Each pin input passes through a synchroniser before any use. A change on a pin can be captured as a rising edge, a falling edge, both, or neither. Captured edges stay in a sticky status register until software clears them by writing ones. One interrupt line is raised while any captured edge is on a pin whose interrupt mask bit is set.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (pin_oe = 0), pin_out = 0, both edge-enable readbacks (0x30 rising, 0x3C falling) and the edge status (0x48) read 0, the mask is zero and irq is 0.
- R2: A write to 0x18 drives high the output latch of each pin whose data bit is 1, and a write to 0x24 drives those latches low; bits written as 0 leave their latch as it was. pin_out shows the latches.
- R3: A write to 0x54 makes each pin with a 1 data bit an output, a write to 0x60 makes such pins inputs; reading 0x0C returns 1 for each output pin, and pin_oe matches that value.
- R4: The rising-edge enables are set through 0x6C and cleared through 0x78 and read at 0x30; the falling-edge enables are set through 0x84, cleared through 0x90 and read at 0x3C; a 1 data bit acts, a 0 bit has no effect.
- R5: Reading 0x00 returns every pin's input after a two-flop synchroniser, regardless of direction: a change applied before one rising clock edge is visible after the second rising edge.
- R6: A change on a pin sets bit n of the status (read at 0x48) only if that edge type is enabled for the pin; with the default two-flop synchroniser the bit is set on the third rising clock edge after the input change.
- R7: A write to 0x48 clears each status bit written as 1; bits written as 0 and bits not written stay as they were.
- R8: If an enabled edge is captured in the same cycle as a write of 1 to that status bit, the bit stays set.
- R9: irq is the OR of the status bits whose mask bit is 1; the mask is set through 0x9C and cleared through 0xA8.
- R10: Writes to the readback addresses 0x00, 0x0C, 0x30 and 0x3C change nothing; reads of any set or clear address, and of unmapped addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| pin_in | input | NPINS (32) | Raw asynchronous pin inputs |
| pin_out | output | NPINS (32) | Output latches toward the pad drivers |
| pin_oe | output | NPINS (32) | Per-pin drive enable, 1 = output |
| irq | output | 1 | Bank interrupt |

## Verification
The bound checker watches on every cycle that the output latches and direction hold unless their own set or clear address is written, that a status bit never drops without a status write, that the interrupt rises only from a captured edge and never while the mask is empty, and that writes to the level readback disturb nothing. The scenarios alone can show the synchroniser latency, which edge types are captured under each enable combination, the precedence of a new edge over a same-cycle clear, the address decode of every register and the zero returned by write-only addresses.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // readback addresses
   localparam logic [7:0] A_LEVEL    = 8'h00;
   localparam logic [7:0] A_DIR      = 8'h0C;
   localparam logic [7:0] A_RISE     = 8'h30;
   localparam logic [7:0] A_FALL     = 8'h3C;
   localparam logic [7:0] A_EDGE     = 8'h48;
   // paired set / clear addresses
   localparam logic [7:0] A_MASK_SET = 8'h9C;
   localparam logic [7:0] A_MASK_CLR = 8'hA8;
   localparam logic [7:0] A_DIR_SET  = 8'h54;
   localparam logic [7:0] A_DIR_CLR  = 8'h60;
   localparam logic [7:0] A_OUT_SET  = 8'h18;
   localparam logic [7:0] A_OUT_CLR  = 8'h24;
   localparam logic [7:0] A_FALL_SET = 8'h84;
   localparam logic [7:0] A_FALL_CLR = 8'h90;
   localparam logic [7:0] A_RISE_SET = 8'h6C;
   localparam logic [7:0] A_RISE_CLR = 8'h78;

   // index of each set/clear controlled register
   localparam int unsigned C_OUT  = 0;
   localparam int unsigned C_DIR  = 1;
   localparam int unsigned C_RISE = 2;
   localparam int unsigned C_FALL = 3;
   localparam int unsigned C_MASK = 4;
   localparam int unsigned N_CTRL = 5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] bits,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= q | bits;
      else if (clr_en) q <= q & ~bits;
   end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] status
);
   logic [W-1:0] level_d;
   logic [W-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= '0;
      else        level_d <= level;
   end

   always_comb begin
      hit = (level & ~level_d & rise_en) | (~level & level_d & fall_en);
   end

   // a fresh edge overrides a clear of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status <= '0;
      else if (clr_en) status <= (status & ~clr_bits) | hit;
      else             status <= status | hit;
   end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned AW          = 8,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq
);
   generate
      if (NPINS > DW || NPINS == 0) begin : g_bad_npins
         $error("gpio_edge_bank: NPINS must be 1..DW");
      end
      if (AW < 8) begin : g_bad_aw
         $error("gpio_edge_bank: AW must be at least 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_edge_bank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam logic [AW-1:0] SET_ADDR [N_CTRL] = '{
      AW'(A_OUT_SET), AW'(A_DIR_SET), AW'(A_RISE_SET), AW'(A_FALL_SET), AW'(A_MASK_SET)};
   localparam logic [AW-1:0] CLR_ADDR [N_CTRL] = '{
      AW'(A_OUT_CLR), AW'(A_DIR_CLR), AW'(A_RISE_CLR), AW'(A_FALL_CLR), AW'(A_MASK_CLR)};

   logic [NPINS-1:0] wbits;
   logic [NPINS-1:0] ctrl_q [N_CTRL];
   logic [NPINS-1:0] level_sync;
   logic [NPINS-1:0] edge_status;
   logic [NPINS-1:0] irq_mask;
   logic             edge_clr;

   assign wbits = bus_wdata[NPINS-1:0];

   genvar c;
   generate
      for (c = 0; c < N_CTRL; c++) begin : g_ctrl
         gpio_setclr_reg #(.W(NPINS)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (bus_we && bus_addr == SET_ADDR[c]),
            .clr_en (bus_we && bus_addr == CLR_ADDR[c]),
            .bits   (wbits),
            .q      (ctrl_q[c])
         );
      end
   endgenerate

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (level_sync)
   );

   assign edge_clr = bus_we && bus_addr == AW'(A_EDGE);

   gpio_edge_status #(.W(NPINS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level_sync),
      .rise_en  (ctrl_q[C_RISE]),
      .fall_en  (ctrl_q[C_FALL]),
      .clr_en   (edge_clr),
      .clr_bits (wbits),
      .status   (edge_status)
   );

   assign pin_out  = ctrl_q[C_OUT];
   assign pin_oe   = ctrl_q[C_DIR];
   assign irq_mask = ctrl_q[C_MASK];
   assign irq      = |(edge_status & irq_mask);

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         AW'(A_LEVEL): bus_rdata[NPINS-1:0] = level_sync;
         AW'(A_DIR):   bus_rdata[NPINS-1:0] = ctrl_q[C_DIR];
         AW'(A_RISE):  bus_rdata[NPINS-1:0] = ctrl_q[C_RISE];
         AW'(A_FALL):  bus_rdata[NPINS-1:0] = ctrl_q[C_FALL];
         AW'(A_EDGE):  bus_rdata[NPINS-1:0] = edge_status;
         default:      bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NPINS = 32,
   parameter int unsigned AW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    bus_addr,
   input logic             bus_we,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] status,
   input logic [NPINS-1:0] mask,
   input logic             irq
);
   logic wr_out, wr_dir, wr_edge, wr_level;
   assign wr_out   = bus_we && (bus_addr == AW'(A_OUT_SET) || bus_addr == AW'(A_OUT_CLR));
   assign wr_dir   = bus_we && (bus_addr == AW'(A_DIR_SET) || bus_addr == AW'(A_DIR_CLR));
   assign wr_edge  = bus_we && bus_addr == AW'(A_EDGE);
   assign wr_level = bus_we && bus_addr == AW'(A_LEVEL);

   // R2: latches move only on their own addresses
   a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out |=> $stable(pin_out));

   // R3: direction moves only on its own addresses
   a_r3_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(pin_oe));

   // R7: captured edges are sticky without a status write
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_edge |=> (($past(status) & ~status) == '0));

   // R9: interrupt needs a captured edge and a non-empty mask
   a_r9_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0 && mask != '0));

   // R10: writing the level readback touches no control state
   a_r10_level_ro: assert property (@(posedge clk) disable iff (!rst_n)
      wr_level |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .status   (edge_status),
   .mask     (irq_mask),
   .irq      (irq)
);

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_edge_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; the write lands on the next posedge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata; bus_addr = 8'hF0;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
   endtask

   // change pins and wait until a captured edge is visible
   task automatic drive_pins(input logic [31:0] v);
      pin_in = v; cycles(3);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 pin_oe", pin_oe, 0);
      check("R1 pin_out", pin_out, 0);
      rd(8'h30, d); check("R1 rise en", d, 0);
      rd(8'h3C, d); check("R1 fall en", d, 0);
      rd(8'h48, d); check("R1 status", d, 0);
      check("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_output();
      wr(8'h18, 32'h0000_00A5); check("R2 set", pin_out, 32'hA5);
      wr(8'h24, 32'h0000_0005); check("R2 clear", pin_out, 32'hA0);
      wr(8'h18, 32'h0);         check("R2 zero bits", pin_out, 32'hA0);
   endtask

   task automatic t_direction();
      logic [31:0] d;
      wr(8'h54, 32'h0000_F0F0);
      rd(8'h0C, d); check("R3 dir set read", d, 32'hF0F0);
      check("R3 pin_oe", pin_oe, 32'hF0F0);
      wr(8'h60, 32'h0000_00F0);
      rd(8'h0C, d); check("R3 dir clear read", d, 32'hF000);
   endtask

   task automatic t_enables();
      logic [31:0] d;
      wr(8'h6C, 32'h0000_000F); wr(8'h78, 32'h0000_0003);
      rd(8'h30, d); check("R4 rise set/clear", d, 32'hC);
      wr(8'h84, 32'h0000_0F00); wr(8'h90, 32'h0000_0100);
      rd(8'h3C, d); check("R4 fall set/clear", d, 32'hE00);
      rd(8'h30, d); check("R4 rise untouched by fall", d, 32'hC);
      wr(8'h78, 32'hFFFF_FFFF); wr(8'h90, 32'hFFFF_FFFF);
      rd(8'h30, d); check("R4 rise all off", d, 0);
      rd(8'h3C, d); check("R4 fall all off", d, 0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      pin_in = 32'h1234_5678;
      cycles(1); rd(8'h00, d); check("R5 level after one edge", d, 0);
      cycles(1); rd(8'h00, d); check("R5 level after two edges", d, 32'h1234_5678);
      pin_in = 32'h0; cycles(4);
      rd(8'h00, d); check("R5 level back to zero", d, 0);
   endtask

   task automatic t_ignored();
      logic [31:0] d;
      wr(8'h00, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h30, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
      check("R10 pin_out kept", pin_out, 32'hA0);
      check("R10 pin_oe kept", pin_oe, 32'hF000);
      rd(8'h30, d); check("R10 rise kept", d, 0);
      rd(8'h3C, d); check("R10 fall kept", d, 0);
      rd(8'h18, d); check("R10 read out set", d, 0);
      rd(8'h54, d); check("R10 read dir set", d, 0);
      rd(8'hA8, d); check("R10 read mask clr", d, 0);
      rd(8'h04, d); check("R10 read unmapped", d, 0);
   endtask

   task automatic t_edges();
      logic [31:0] d;
      // bit0 rise, bit1 fall, bit2 both, bit3 none
      wr(8'h6C, 32'h5); wr(8'h84, 32'h6);
      pin_in = 32'hF; cycles(2);
      rd(8'h48, d); check("R6 not yet captured", d, 0);
      cycles(1);
      rd(8'h48, d); check("R6 rising capture", d, 32'h5);
      wr(8'h48, 32'hF);
      drive_pins(32'h0);
      rd(8'h48, d); check("R6 falling capture", d, 32'h6);
      wr(8'h48, 32'hF);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      drive_pins(32'hF);
      wr(8'h48, 32'h1);
      rd(8'h48, d); check("R7 partial clear", d, 32'h4);
      cycles(5);
      rd(8'h48, d); check("R7 sticky", d, 32'h4);
      wr(8'h48, 32'h4);
      rd(8'h48, d); check("R7 full clear", d, 0);
      drive_pins(32'h0); wr(8'h48, 32'hFFFF_FFFF);
   endtask

   task automatic t_race();
      logic [31:0] d;
      drive_pins(32'h4);
      rd(8'h48, d); check("R8 setup", d, 32'h4);
      pin_in = 32'h0; cycles(2);
      wr(8'h48, 32'h4); // lands on the capture edge
      rd(8'h48, d); check("R8 edge wins", d, 32'h4);
      wr(8'h48, 32'h4);
      rd(8'h48, d); check("R8 plain clear", d, 0);
   endtask

   task automatic t_irq();
      drive_pins(32'h1);
      check("R9 masked", {31'd0, irq}, 0);
      wr(8'h9C, 32'h1); check("R9 unmasked", {31'd0, irq}, 1);
      wr(8'hA8, 32'h1); check("R9 mask cleared", {31'd0, irq}, 0);
      wr(8'h9C, 32'h2); check("R9 other bit mask", {31'd0, irq}, 0);
      wr(8'h9C, 32'h1); check("R9 remasked", {31'd0, irq}, 1);
      wr(8'h48, 32'h1); check("R9 status cleared", {31'd0, irq}, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      bus_addr = 8'hF0;
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_output();
      t_direction();
      t_enables();
      t_level();
      t_ignored();
      t_edges();
      t_w1c();
      t_race();
      t_irq();
      finish_run();
   end

   initial begin
      #(20 * 20000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule